// File: doc/BRIEF.md
# Burst-of-Two Dual-Port Memory Core

This block is a synchronous memory core with separate input and output data buses. The core takes one read burst and one write burst in every request cycle. Each burst moves two bus-width beats. Storage is a single array whose words are twice the bus width, so each burst costs exactly one array access. On the write side, the first beat is parked in a register. When the second beat arrives, both halves are written together. On the read side, one full word is fetched and then played out as two beats after a fixed latency.

The logic clock advances one beat slot per edge. A request cycle is two consecutive slots: a first slot and a second slot, shown on `beat_ph`. The single address bus is time-shared. It carries the read address in the first slot and the write address in the second slot. Because of this, one single-port array serves both operations without conflict. Write beats are qualified by their own data strobe, which is independent of the request strobes. Read beats leave with a valid flag. An address selects a two-beat word, so the address is one bit narrower than a beat-level address would be.

Top module: `b2sram_core`

## Requirements
- R1: After reset `beat_ph` is 0 (first slot) and it toggles on every clock. A request cycle is a slot with `beat_ph`=0 followed by a slot with `beat_ph`=1.
- R2: `rd_req` and `addr` are sampled only in a first slot. A `rd_req` raised in a second slot is ignored and produces no output beats.
- R3: For a read accepted in first slot 2k, the lower half of the addressed word appears on `rdata` in slot 2k+6 and the upper half in slot 2k+7. That is 3 request cycles later.
- R4: `rd_vld` is high in exactly those two slots of each accepted read. `rdata` is all zeros in every slot where `rd_vld` is low.
- R5: `wr_req` and `addr` are sampled only in a second slot. The lower write beat is the `wdata` of the first slot of the same request cycle, and the upper beat is the `wdata` of the second slot. Both are written to the array in one access at the end of the second slot. A `wr_req` in a first slot is ignored.
- R6: A write is dropped, leaving the array unchanged, unless `wd_stb` is high in both slots of its request cycle.
- R7: A read and a write to the same address in one request cycle return the data held before the write. A read of that address in the next request cycle returns the new data.
- R8: Reads and writes to different addresses may be issued in every request cycle back to back with no idle cycles. Each read returns the data of its own address.
- R9: `DATA_W` selects a beat width of 18 or 36 bits. The array word is 2*`DATA_W` bits, and `ADDR_W` address bits select one two-beat word.
- R10: Reset clears the slot phase, the read pipeline and the output flag. A read in flight is lost, but data written before the reset stays readable after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat-slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read burst request, taken in a first slot |
| wr_req | input | 1 | Write burst request, taken in a second slot |
| addr | input | ADDR_W | Shared address: read address in first slot, write address in second slot |
| wd_stb | input | 1 | Write data strobe, qualifies the beat on `wdata` in the same slot |
| wdata | input | DATA_W | Write data beat |
| beat_ph | output | 1 | Slot phase, 0 = first slot, 1 = second slot |
| rdata | output | DATA_W | Read data beat, zero when not valid |
| rd_vld | output | 1 | Read beat valid |

## Verification
The main function is first tried with a stream that issues a read and a write in every request cycle to different addresses. This separates correct per-burst word selection and lower/upper beat order from mixed-up halves or addresses. A same-address read and write in one cycle, followed by a read in the next cycle, tells read-before-write apart from write-through and from stale reads. Requests placed in the wrong slot, and writes missing one strobe, must leave both the outputs and the array untouched. A reset issued with a read in flight must drop that read while the stored words survive. Two instances with 18- and 36-bit beats are run with the same stimulus, so width-dependent packing errors show up.

// File: rtl/b2sram_pkg.sv
package b2sram_pkg;

  // Slot phase inside one request cycle
  typedef enum logic {
    SLOT_FIRST  = 1'b0,
    SLOT_SECOND = 1'b1
  } slot_e;

  // Read latency counted in beat slots
  function automatic int lat_slots(input int rd_lat_cyc);
    return 2 * rd_lat_cyc;
  endfunction

  // Word-carrying stages between the array read register and the output register
  function automatic int pipe_stages(input int rd_lat_cyc);
    return 2 * rd_lat_cyc - 2;
  endfunction

endpackage

// File: rtl/b2sram_wr_demux.sv
module b2sram_wr_demux
  import b2sram_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  slot_e                 ph,
  input  logic                  wr_req,
  input  logic                  wd_stb,
  input  logic [DATA_W-1:0]     wdata,
  output logic                  commit,
  output logic [2*DATA_W-1:0]   word
);

  logic [DATA_W-1:0] lo_q;
  logic              lo_ok;

  // Park the lower beat taken in the first slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      lo_ok <= 1'b0;
    end else if (ph == SLOT_FIRST) begin
      lo_ok <= wd_stb;
      if (wd_stb) lo_q <= wdata;
    end else begin
      lo_ok <= 1'b0;
    end
  end

  // Upper beat goes straight from the bus into the array write
  assign commit = (ph == SLOT_SECOND) && wr_req && wd_stb && lo_ok;
  assign word   = {wdata, lo_q};

endmodule

// File: rtl/b2sram_array.sv
module b2sram_array #(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdat,
  output logic [WORD_W-1:0] rdat
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // One access per slot: reads in first slots, writes in second slots
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdat;
    if (rd_en) rdat <= mem[addr];
  end

endmodule

// File: rtl/b2sram_rd_pipe.sv
module b2sram_rd_pipe #(
  parameter int DATA_W = 18,
  parameter int NSTG   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_acc,
  input  logic [2*DATA_W-1:0]   word_in,
  output logic                  fetch_vld,
  output logic [DATA_W-1:0]     beat,
  output logic                  beat_vld
);

  localparam int WORD_W = 2 * DATA_W;

  logic              s_v [NSTG];
  logic [WORD_W-1:0] s_d [NSTG];
  logic [DATA_W-1:0] hold_q;
  logic              pend_q;

  // Valid travels with the array read register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fetch_vld <= 1'b0;
    else        fetch_vld <= rd_acc;
  end

  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_v[i] <= 1'b0;
          s_d[i] <= '0;
        end else begin
          s_v[i] <= fetch_vld;
          s_d[i] <= word_in;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_v[i] <= 1'b0;
          s_d[i] <= '0;
        end else begin
          s_v[i] <= s_v[i-1];
          s_d[i] <= s_d[i-1];
        end
      end
    end
  end

  // Output multiplexer: lower half first, then the held upper half
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat     <= '0;
      beat_vld <= 1'b0;
      hold_q   <= '0;
      pend_q   <= 1'b0;
    end else if (s_v[NSTG-1]) begin
      beat     <= s_d[NSTG-1][DATA_W-1:0];
      hold_q   <= s_d[NSTG-1][WORD_W-1:DATA_W];
      pend_q   <= 1'b1;
      beat_vld <= 1'b1;
    end else if (pend_q) begin
      beat     <= hold_q;
      pend_q   <= 1'b0;
      beat_vld <= 1'b1;
    end else begin
      beat     <= '0;
      beat_vld <= 1'b0;
    end
  end

endmodule

// File: rtl/b2sram_core.sv
module b2sram_core
  import b2sram_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4,
  parameter int RD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wd_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic              beat_ph,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_vld
);

  localparam int WORD_W = 2 * DATA_W;
  localparam int NSTG   = pipe_stages(RD_LAT);

  slot_e             ph;
  logic              rd_acc;
  logic              wr_commit;
  logic              fetch_vld;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= SLOT_FIRST;
    else        ph <= slot_e'(~ph);
  end

  assign beat_ph = (ph == SLOT_SECOND);
  assign rd_acc  = rd_req && (ph == SLOT_FIRST);

  b2sram_wr_demux #(.DATA_W(DATA_W)) u_demux (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph     (ph),
    .wr_req (wr_req),
    .wd_stb (wd_stb),
    .wdata  (wdata),
    .commit (wr_commit),
    .word   (wr_word)
  );

  b2sram_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .rd_en (rd_acc),
    .wr_en (wr_commit),
    .addr  (addr),
    .wdat  (wr_word),
    .rdat  (rd_word)
  );

  b2sram_rd_pipe #(.DATA_W(DATA_W), .NSTG(NSTG)) u_rdpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_acc    (rd_acc),
    .word_in   (rd_word),
    .fetch_vld (fetch_vld),
    .beat      (rdata),
    .beat_vld  (rd_vld)
  );

endmodule

// File: rtl/b2sram_chk.sv
module b2sram_chk
  import b2sram_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int RD_LAT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_acc,
  input logic              wr_commit,
  input logic              wr_req,
  input logic              wd_stb,
  input logic              beat_ph,
  input logic              rd_vld,
  input logic [DATA_W-1:0] rdata
);

  localparam int L2 = lat_slots(RD_LAT);

  // Record of accepted reads, one bit per elapsed slot
  logic [L2:0] acc_sr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_sr <= '0;
    else        acc_sr <= {acc_sr[L2-1:0], rd_acc};
  end

  a_r1_ph_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> beat_ph != $past(beat_ph));

  a_r3_vld_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld == (acc_sr[L2-1] || acc_sr[L2]));

  a_r3_beat_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_vld) |=> rd_vld);

  a_r4_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vld |-> rdata == '0);

  a_r6_both_beats: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (wd_stb && $past(wd_stb) && wr_req && beat_ph));

endmodule

bind b2sram_core b2sram_chk #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_acc    (rd_acc),
  .wr_commit (wr_commit),
  .wr_req    (wr_req),
  .wd_stb    (wd_stb),
  .beat_ph   (beat_ph),
  .rd_vld    (rd_vld),
  .rdata     (rdata)
);

// File: tb/b2sram_core_bench.sv
module b2sram_core_bench;

  localparam int CLK_P  = 10;
  localparam int AW     = 4;
  localparam int NW     = 1 << AW;
  localparam int WD_CYC = 20000;

  typedef struct packed {
    logic        r0;
    logic        r1;
    logic        w0;
    logic        w1;
    logic        s0;
    logic        s1;
    logic [3:0]  a0;
    logic [3:0]  a1;
    logic [17:0] d0;
    logic [17:0] d1;
  } vec_t;

  // Back-to-back stream: a read and a write in every request cycle (R8)
  localparam int NTBL = 12;
  localparam vec_t TBL [NTBL] = '{
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,4'd1, 4'd2, 18'h3A5C1,18'h0F0F0},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,4'd2, 4'd3, 18'h12345,18'h2BEEF},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,4'd3, 4'd3, 18'h00001,18'h3FFFF},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3, 4'd0, 18'h0,    18'h0},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,4'd15,4'd15,18'h15555,18'h2AAAA},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,4'd0, 4'd0, 18'h3FFFF,18'h00000},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,4'd15,4'd4, 18'h0C0C0,18'h30303},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0, 4'd0, 18'h0,    18'h0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd4, 4'd0, 18'h0,    18'h0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0, 4'd0, 18'h0,    18'h0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0, 4'd0, 18'h0,    18'h0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0, 4'd0, 18'h0,    18'h0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_req = 1'b0;
  logic          wr_req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wd_stb = 1'b0;
  logic [17:0]   wdata = '0;
  logic [35:0]   wdata36;
  logic          beat_ph, rd_vld, beat_ph36, rd_vld36;
  logic [17:0]   rdata;
  logic [35:0]   rdata36;

  assign wdata36 = {~wdata, wdata};

  always #(CLK_P/2) clk = ~clk;

  b2sram_core #(.DATA_W(18), .ADDR_W(AW), .RD_LAT(3)) u_b2sram_core (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
    .wd_stb(wd_stb), .wdata(wdata), .beat_ph(beat_ph), .rdata(rdata), .rd_vld(rd_vld)
  );

  b2sram_core #(.DATA_W(36), .ADDR_W(AW), .RD_LAT(3)) u_b2sram_core_w36 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
    .wd_stb(wd_stb), .wdata(wdata36), .beat_ph(beat_ph36), .rdata(rdata36), .rd_vld(rd_vld36)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  logic [17:0] m_lo [NW];
  logic [17:0] m_hi [NW];
  logic        exp_v  [4];
  logic [17:0] exp_lo [4];
  logic [17:0] exp_hi [4];
  string       exp_tag [4];

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check_slot(input logic v, input logic [17:0] e, input logic ph, input string tag);
    chk("R1", {35'd0, beat_ph}, {35'd0, ph}, "slot phase");
    chk(v ? "R3" : "R4", {35'd0, rd_vld}, {35'd0, v}, {tag, " valid flag"});
    chk(v ? "R3" : "R4", {18'd0, rdata}, v ? {18'd0, e} : 36'd0, {tag, " read beat"});
    chk("R9", {35'd0, rd_vld36}, {35'd0, v}, {tag, " wide valid flag"});
    chk("R9", rdata36, v ? {~e, e} : 36'd0, {tag, " wide read beat"});
  endtask

  // Entered and left at a negedge inside a first slot
  task automatic run_cycle(input vec_t v, input string tag);
    int idx, nidx;
    idx  = cyc % 4;
    nidx = (cyc + 3) % 4;
    rd_req = v.r0; wr_req = v.w0; addr = v.a0; wd_stb = v.s0; wdata = v.d0;
    check_slot(exp_v[idx], exp_lo[idx], 1'b0, exp_tag[idx]);
    exp_v[nidx]   = v.r0;
    exp_lo[nidx]  = m_lo[v.a0];
    exp_hi[nidx]  = m_hi[v.a0];
    exp_tag[nidx] = tag;
    @(negedge clk);
    rd_req = v.r1; wr_req = v.w1; addr = v.a1; wd_stb = v.s1; wdata = v.d1;
    check_slot(exp_v[idx], exp_hi[idx], 1'b1, exp_tag[idx]);
    if (v.w1 && v.s0 && v.s1) begin
      m_lo[v.a1] = v.d0;
      m_hi[v.a1] = v.d1;
    end
    exp_v[idx] = 1'b0;
    cyc++;
    @(negedge clk);
  endtask

  function automatic vec_t mk(input logic r0, input logic [3:0] a0, input logic w1,
                              input logic [3:0] a1, input logic s0, input logic s1,
                              input logic [17:0] d0, input logic [17:0] d1);
    vec_t v;
    v = '{r0, 1'b0, 1'b0, w1, s0, s1, a0, a1, d0, d1};
    return v;
  endfunction

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) run_cycle(mk(1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 18'd0, 18'd0), tag);
  endtask

  task automatic do_reset();
    rd_req = 1'b0; wr_req = 1'b0; wd_stb = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) exp_v[i] = 1'b0;
    cyc = 0;
    chk("R10", {35'd0, beat_ph}, 36'd0, "phase after reset");
    chk("R10", {35'd0, rd_vld}, 36'd0, "valid after reset");
    chk("R10", {18'd0, rdata}, 36'd0, "data after reset");
    chk("R10", {35'd0, rd_vld36}, 36'd0, "wide valid after reset");
  endtask

  initial begin : watchdog
    repeat (WD_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin : stim
    vec_t v;
    for (int i = 0; i < 4; i++) begin
      exp_v[i] = 1'b0; exp_lo[i] = '0; exp_hi[i] = '0; exp_tag[i] = "R4";
    end
    @(negedge clk);
    do_reset();

    // Fill every word (R5, R9)
    for (int i = 0; i < NW; i++)
      run_cycle(mk(1'b0, 4'd0, 1'b1, 4'(i), 1'b1, 1'b1, 18'(i * 1021 + 3), 18'(i * 2053 + 7)), "R5");
    for (int i = 0; i < NW; i++)
      run_cycle(mk(1'b1, 4'(i), 1'b0, 4'd0, 1'b0, 1'b0, 18'd0, 18'd0), "R5");
    idle(3, "R4");

    // Vector walk: read and write in every cycle (R8)
    for (int i = 0; i < NTBL; i++) run_cycle(TBL[i], "R8");

    // R7: same address in one cycle reads old, next cycle reads new
    run_cycle(mk(1'b1, 4'd6, 1'b1, 4'd6, 1'b1, 1'b1, 18'h2D2D2, 18'h1B1B1), "R7");
    run_cycle(mk(1'b1, 4'd6, 1'b0, 4'd0, 1'b0, 1'b0, 18'd0, 18'd0), "R7");
    idle(3, "R7");

    // R6: a write missing either strobe leaves the word unchanged
    run_cycle(mk(1'b0, 4'd0, 1'b1, 4'd7, 1'b0, 1'b1, 18'h11111, 18'h22222), "R6");
    run_cycle(mk(1'b0, 4'd0, 1'b1, 4'd8, 1'b1, 1'b0, 18'h33333, 18'h04444), "R6");
    run_cycle(mk(1'b1, 4'd7, 1'b0, 4'd0, 1'b0, 1'b0, 18'd0, 18'd0), "R6");
    run_cycle(mk(1'b1, 4'd8, 1'b0, 4'd0, 1'b0, 1'b0, 18'd0, 18'd0), "R6");
    idle(3, "R6");

    // R2: read strobe in a second slot is ignored
    v = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd9, 18'd0, 18'd0};
    run_cycle(v, "R2");
    idle(3, "R2");

    // R5: write strobe in a first slot is ignored
    v = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd9, 4'd9, 18'h3C3C3, 18'h03C3C};
    run_cycle(v, "R5");
    run_cycle(mk(1'b1, 4'd9, 1'b0, 4'd0, 1'b0, 1'b0, 18'd0, 18'd0), "R5");
    idle(3, "R5");

    // R10: reset drops a read in flight but keeps the array
    run_cycle(mk(1'b1, 4'd2, 1'b0, 4'd0, 1'b0, 1'b0, 18'd0, 18'd0), "R10");
    do_reset();
    idle(3, "R10");
    run_cycle(mk(1'b1, 4'd2, 1'b0, 4'd0, 1'b0, 1'b0, 18'd0, 18'd0), "R10");
    run_cycle(mk(1'b1, 4'd6, 1'b0, 4'd0, 1'b0, 1'b0, 18'd0, 18'd0), "R10");
    run_cycle(mk(1'b1, 4'd15, 1'b0, 4'd0, 1'b0, 1'b0, 18'd0, 18'd0), "R10");
    idle(4, "R10");

    summary();
    $finish;
  end

endmodule